// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Snoop

This block is a small pool of waiting slots placed in front of one class of functional unit in an out-of-order core. The issue stage hands it one instruction at a time. Each source operand arrives either as a finished value or as the tag of the slot that will produce it. The pool keeps each instruction in a free slot and watches the single result bus. When a broadcast tag equals a tag a slot is waiting on, the slot takes the value. A slot is offered to the functional unit once none of its operands is still waiting.

Operands are copied into the slot at issue, or stand as producer tags until they are resolved. Because of this, reuse of register names never holds an instruction back. The only stall left is structural: if every slot is occupied, the issue request is refused and the issuer must hold it. Each slot's fixed identifier is the tag under which its result will later be broadcast. An instruction that arrives with both operands resolved can be offered to the unit in the cycle it is issued.

Top module: `rs_pool`

## Requirements
- R1: While reset is held and in the first cycle after it, every slot is free, `iss_ready` is 1 and `disp_valid` is 0.
- R2: A source given with tag 0 (the null tag) is ready and its value is stored; the dispatched operand equals the value given at issue.
- R3: A slot is offered on `disp_valid` only when both of its source tags are null; a slot holding a nonzero source tag is never dispatched.
- R4: An instruction issued with both sources ready, into an otherwise idle pool, drives `disp_valid` and its opcode and operands combinationally in the issue cycle itself. If it is accepted in that cycle, no slot stays occupied.
- R5: A bus broadcast whose tag equals a waiting source tag replaces that operand by the bus value and clears the tag, so the slot is ready from the next cycle. A broadcast whose tag matches no waiting source changes nothing.
- R6: A single broadcast wakes every waiting source that carries its tag, in any number of slots and in either operand position.
- R7: Slot i has the fixed tag i+1. `iss_dst_tag` gives the tag of the slot an issue would take, which is the lowest-index free slot, and `disp_tag` gives the tag of the dispatched slot.
- R8: Among the ready slots the lowest index is dispatched. A slot is freed in the cycle after `disp_accept` is high together with `disp_valid`. Without acceptance it keeps being offered unchanged.
- R9: When all slots are busy, `iss_ready` is 0 and an issue request is ignored: no slot is written and nothing is dispatched from it.
- R10: A broadcast in the same cycle as an issue whose source names that tag is taken at issue, so that source is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Opcode of the issued instruction |
| iss_a_tag | input | 4 | Producer tag of source A, 0 when ready |
| iss_a_val | input | 16 | Value of source A when ready |
| iss_b_tag | input | 4 | Producer tag of source B, 0 when ready |
| iss_b_val | input | 16 | Value of source B when ready |
| iss_ready | output | 1 | A slot is free; the request is taken |
| iss_dst_tag | output | 4 | Tag of the slot an issue goes into |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | 4 | Tag of the broadcasting producer |
| bus_val | input | 16 | Broadcast result value |
| disp_valid | output | 1 | A ready instruction is offered |
| disp_op | output | 4 | Opcode of the offered instruction |
| disp_a | output | 16 | Operand A of the offered instruction |
| disp_b | output | 16 | Operand B of the offered instruction |
| disp_tag | output | 4 | Destination tag of the offered instruction |
| disp_accept | input | 1 | Functional unit takes the offered instruction |

## Verification
The bench builds the pool with two slots, so filling it takes two issues. A full stall, a refused request and a single broadcast that wakes every slot at once all fit in a few cycles. It sweeps a range of ready-operand values through the same-cycle start path. Both slots are then held on one tag, once in each operand position, to show that one broadcast wakes both and that dispatch follows the lowest-index order. A broadcast with a foreign tag and a broadcast arriving together with an issue are exercised against the same small pool.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;

    localparam tag_t TAG_NULL = '0;

    typedef struct packed {
        tag_t  tag;
        data_t val;
    } opnd_t;

    typedef struct packed {
        logic  busy;
        op_t   op;
        opnd_t a;
        opnd_t b;
    } slot_t;

    // Resolve one operand against the result bus.
    function automatic opnd_t snoop(opnd_t o, logic hit_v, tag_t hit_tag, data_t hit_val);
        opnd_t r;
        r = o;
        if (o.tag != TAG_NULL && hit_v && o.tag == hit_tag) begin
            r.tag = TAG_NULL;
            r.val = hit_val;
        end
        return r;
    endfunction

    function automatic logic opnd_ready(opnd_t o);
        return o.tag == TAG_NULL;
    endfunction

    // Fixed producer tag of a slot position.
    function automatic tag_t slot_tag(int idx);
        return tag_t'(idx + 1);
    endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N     = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  slot_t load_val,
    input  logic  release_i,
    input  logic  bus_valid,
    input  tag_t  bus_tag,
    input  data_t bus_val,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (release_i) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (q.busy) begin
            q.a <= snoop(q.a, bus_valid, bus_tag, bus_val);
            q.b <= snoop(q.b, bus_valid, bus_tag, bus_val);
        end
    end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_dst_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_val,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              disp_accept
);
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    slot_t              cur [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] busy_vec;
    logic [NUM_SLOTS-1:0] rdy_vec;
    logic [IDX_W-1:0]   alloc_idx;
    logic [IDX_W-1:0]   sel_idx;
    logic               have_free;
    logic               iss_fire;
    logic               disp_fire;
    opnd_t              new_a;
    opnd_t              new_b;
    slot_t              new_slot;
    logic               new_ready;

    // Issue-side operands, with same-cycle bus forwarding.
    always_comb begin
        new_a     = snoop('{tag: iss_a_tag, val: iss_a_val}, bus_valid, bus_tag, bus_val);
        new_b     = snoop('{tag: iss_b_tag, val: iss_b_val}, bus_valid, bus_tag, bus_val);
        new_slot  = '{busy: 1'b1, op: iss_op, a: new_a, b: new_b};
        new_ready = opnd_ready(new_a) && opnd_ready(new_b);
    end

    rs_pick #(.N(NUM_SLOTS)) u_alloc (
        .req   (~busy_vec),
        .found (have_free),
        .idx   (alloc_idx)
    );

    assign iss_ready   = have_free;
    assign iss_fire    = iss_valid && have_free;
    assign iss_dst_tag = slot_tag(int'(alloc_idx));

    rs_pick #(.N(NUM_SLOTS)) u_sel (
        .req   (rdy_vec),
        .found (disp_valid),
        .idx   (sel_idx)
    );

    assign disp_fire = disp_valid && disp_accept;

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            logic is_alloc;
            logic is_sel;
            assign is_alloc    = iss_fire && (alloc_idx == IDX_W'(i));
            assign is_sel      = disp_fire && (sel_idx == IDX_W'(i));
            assign busy_vec[i] = cur[i].busy;
            assign rdy_vec[i]  = cur[i].busy
                               ? (opnd_ready(cur[i].a) && opnd_ready(cur[i].b))
                               : (is_alloc && new_ready);

            rs_slot u_slot (
                .clk       (clk),
                .rst       (rst),
                .load      (is_alloc && !is_sel),
                .load_val  (new_slot),
                .release_i (is_sel && cur[i].busy),
                .bus_valid (bus_valid),
                .bus_tag   (bus_tag),
                .bus_val   (bus_val),
                .q         (cur[i])
            );
        end
    endgenerate

    // Stored slot wins its position; otherwise the bypassed issue is shown.
    always_comb begin
        if (cur[sel_idx].busy) begin
            disp_op = cur[sel_idx].op;
            disp_a  = cur[sel_idx].a.val;
            disp_b  = cur[sel_idx].b.val;
        end else begin
            disp_op = new_slot.op;
            disp_a  = new_slot.a.val;
            disp_b  = new_slot.b.val;
        end
        disp_tag = slot_tag(int'(sel_idx));
    end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 iss_valid,
    input logic                 iss_ready,
    input logic [TAG_W-1:0]     iss_dst_tag,
    input logic                 disp_valid,
    input logic                 disp_accept,
    input logic [TAG_W-1:0]     disp_tag,
    input logic [NUM_SLOTS-1:0] busy_vec
);
    logic [NUM_SLOTS-1:0] dst_mask;
    logic [NUM_SLOTS-1:0] disp_mask;

    assign dst_mask  = NUM_SLOTS'(1) << (iss_dst_tag - TAG_W'(1));
    assign disp_mask = NUM_SLOTS'(1) << (disp_tag - TAG_W'(1));

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (busy_vec == '0)); // R1

    AST_DISP_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (busy_vec != '0 || (iss_valid && iss_ready))); // R3

    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_tag != '0 && int'(disp_tag) <= NUM_SLOTS)); // R7

    AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && !(disp_valid && disp_accept && disp_tag == iss_dst_tag))
        |=> ((busy_vec & $past(dst_mask)) != '0)); // R2

    AST_ACCEPT_FREES: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_accept && (busy_vec & disp_mask) != '0)
        |=> ((busy_vec & $past(disp_mask)) == '0)); // R8

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !(disp_valid && disp_accept))
        |=> (busy_vec == $past(busy_vec))); // R9
endmodule

bind rs_pool rs_pool_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_valid   (iss_valid),
    .iss_ready   (iss_ready),
    .iss_dst_tag (iss_dst_tag),
    .disp_valid  (disp_valid),
    .disp_accept (disp_accept),
    .disp_tag    (disp_tag),
    .busy_vec    (busy_vec)
);

// File: tb/rs_pool_bench.sv
`timescale 1ns/100ps
module rs_pool_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid;
    logic [3:0]  iss_op;
    logic [3:0]  iss_a_tag;
    logic [15:0] iss_a_val;
    logic [3:0]  iss_b_tag;
    logic [15:0] iss_b_val;
    logic        iss_ready;
    logic [3:0]  iss_dst_tag;
    logic        bus_valid;
    logic [3:0]  bus_tag;
    logic [15:0] bus_val;
    logic        disp_valid;
    logic [3:0]  disp_op;
    logic [15:0] disp_a;
    logic [15:0] disp_b;
    logic [3:0]  disp_tag;
    logic        disp_accept;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rs_pool #(.NUM_SLOTS(2)) u_rs_pool (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_ready(iss_ready), .iss_dst_tag(iss_dst_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
        .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag),
        .disp_accept(disp_accept)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_op = '0;
        iss_a_tag = '0; iss_a_val = '0; iss_b_tag = '0; iss_b_val = '0;
        bus_valid = 1'b0; bus_tag = '0; bus_val = '0;
    endtask

    task automatic issue(logic [3:0] op, logic [3:0] at, logic [15:0] av,
                         logic [3:0] bt, logic [15:0] bv);
        iss_valid = 1'b1; iss_op = op;
        iss_a_tag = at; iss_a_val = av; iss_b_tag = bt; iss_b_val = bv;
    endtask

    task automatic bcast(logic [3:0] t, logic [15:0] v);
        bus_valid = 1'b1; bus_tag = t; bus_val = v;
    endtask

    // Pass one rising edge, land on the falling edge, clear the inputs.
    task automatic tick();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        idle();
        disp_accept = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 ready in reset", 32'(iss_ready), 1);
        check("R1 no dispatch in reset", 32'(disp_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 ready after reset", 32'(iss_ready), 1);
        check("R1 idle after reset", 32'(disp_valid), 0);
        check("R7 first tag", 32'(iss_dst_tag), 1);

        // R4 / R2: sweep of ready-operand issues started in the same cycle
        disp_accept = 1'b1;
        for (int k = 0; k < 8; k++) begin
            issue(4'(k), 4'd0, 16'(k * 37 + 5), 4'd0, 16'(1000 - k * 11));
            #1;
            check("R4 same-cycle valid", 32'(disp_valid), 1);
            check("R2 operand a", 32'(disp_a), 32'(k * 37 + 5));
            check("R2 operand b", 32'(disp_b), 32'(1000 - k * 11));
            check("R4 opcode", 32'(disp_op), 32'(k));
            check("R7 tag of slot 0", 32'(disp_tag), 1);
            tick();
            check("R4 nothing left", 32'(disp_valid), 0);
            check("R8 slot free again", 32'(iss_dst_tag), 1);
        end
        disp_accept = 1'b0;

        // R3 / R9: fill both slots with waiting instructions
        issue(4'd2, 4'd5, 16'd0, 4'd0, 16'd2);
        #1;
        check("R7 dst tag slot 0", 32'(iss_dst_tag), 1);
        check("R3 waiting not offered", 32'(disp_valid), 0);
        tick();
        issue(4'd4, 4'd0, 16'd3, 4'd5, 16'd0);
        #1;
        check("R7 dst tag slot 1", 32'(iss_dst_tag), 2);
        check("R3 waiting not offered 2", 32'(disp_valid), 0);
        tick();
        check("R9 full refuses", 32'(iss_ready), 0);
        disp_accept = 1'b1;
        issue(4'd7, 4'd0, 16'd99, 4'd0, 16'd98);
        #1;
        check("R9 refused not dispatched", 32'(disp_valid), 0);
        tick();
        disp_accept = 1'b0;
        check("R9 still full", 32'(iss_ready), 0);
        check("R9 nothing ready", 32'(disp_valid), 0);

        // R5: foreign broadcast is ignored
        bcast(4'd7, 16'd55);
        tick();
        check("R5 foreign tag ignored", 32'(disp_valid), 0);
        check("R5 foreign tag full", 32'(iss_ready), 0);

        // R6: one broadcast wakes both slots, R8 lowest index first
        bcast(4'd5, 16'd40);
        #1;
        check("R5 capture is registered", 32'(disp_valid), 0);
        tick();
        check("R6 woken valid", 32'(disp_valid), 1);
        check("R8 lowest first tag", 32'(disp_tag), 1);
        check("R5 captured a", 32'(disp_a), 40);
        check("R2 kept b", 32'(disp_b), 2);
        check("R6 opcode slot 0", 32'(disp_op), 2);
        tick();
        check("R8 held without accept", 32'(disp_tag), 1);
        check("R8 held value", 32'(disp_a), 40);
        check("R8 still full", 32'(iss_ready), 0);
        disp_accept = 1'b1;
        tick();
        disp_accept = 1'b0;
        check("R8 freed after accept", 32'(iss_ready), 1);
        check("R6 second woken", 32'(disp_valid), 1);
        check("R6 second tag", 32'(disp_tag), 2);
        check("R6 second a", 32'(disp_a), 3);
        check("R6 second b captured", 32'(disp_b), 40);
        check("R6 second opcode", 32'(disp_op), 4);
        disp_accept = 1'b1;
        tick();
        disp_accept = 1'b0;
        check("R8 all drained", 32'(disp_valid), 0);
        check("R8 ready again", 32'(iss_ready), 1);

        // R10: broadcast in the issue cycle is forwarded
        issue(4'd9, 4'd9, 16'd0, 4'd0, 16'd1);
        bcast(4'd9, 16'd77);
        #1;
        check("R10 forwarded ready", 32'(disp_valid), 1);
        check("R10 forwarded value", 32'(disp_a), 77);
        tick();
        check("R10 stored ready", 32'(disp_valid), 1);
        check("R10 stored value", 32'(disp_a), 77);
        check("R10 stored b", 32'(disp_b), 1);
        disp_accept = 1'b1;
        tick();
        disp_accept = 1'b0;
        check("R10 drained", 32'(disp_valid), 0);

        // R5: non-matching bus at issue leaves the source waiting
        issue(4'd1, 4'd9, 16'd0, 4'd0, 16'd6);
        bcast(4'd10, 16'd88);
        #1;
        check("R5 no forward on mismatch", 32'(disp_valid), 0);
        tick();
        check("R3 still waiting", 32'(disp_valid), 0);
        bcast(4'd9, 16'd21);
        tick();
        check("R5 late capture valid", 32'(disp_valid), 1);
        check("R5 late capture a", 32'(disp_a), 21);
        disp_accept = 1'b1;
        tick();
        disp_accept = 1'b0;
        check("R8 final drain", 32'(disp_valid), 0);

        summary();
    end
endmodule